// File: doc/BRIEF.md
# Latched Seconds Counter With Prescaler

This block keeps a 32-bit elapsed-seconds count that moves up by one each time its own divider chain has seen 4096 tick enables. The divider has two sections. A short front section counts raw ticks and gives a fast tap. A longer back section counts the front section's wraps and produces the once-per-second carry. A selectable square wave is taken from the raw tick, from the fast tap or from the top of the back section.

Software reaches the count through a byte-wide register port with four addresses. A read of the lowest address copies the whole live count into a holding register. The other addresses return bytes from that copy while the live counter keeps running. Written bytes wait in a staging register, and the write to the highest address loads all 32 bits at once. That same write clears only the back divider section. The 1 Hz square wave therefore starts a fresh period, and the faster taps keep their phase.

Top module: `sec_counter_top`

## Requirements
- R1: After reset the count is zero, `reg_rdata` is 0x00 and `sqw_out` is low.
- R2: With no load pending, the count increases by exactly one on the tick that completes each run of 4096 tick enables (4 front-section ticks times 1024 back-section wraps), and it never changes without a tick.
- R3: A read strobe at address 0 returns the live count's bits 7:0 on `reg_rdata` in the next cycle and latches all 32 bits. Addresses 1, 2 and 3 return bits 15:8, 23:16 and 31:24 of that latched copy.
- R4: Reads at addresses 1 to 3 return the latched copy even after the live count has moved on. Only a new read at address 0 refreshes the copy.
- R5: Writes at addresses 0, 1 and 2 only stage bytes 7:0, 15:8 and 23:16 and leave the count unchanged. A write at address 3 loads {data, staged bytes} into the count in one step.
- R6: A write at address 3 clears the back divider section while the front section keeps its state. The next increment then comes after (4 − front phase) + 1023×4 further ticks.
- R7: With `sqw_sel` = 2 (1 Hz), `sqw_out` follows the top bit of the back section, so it is high for the second half of each 4096-tick period and is forced low by a write at address 3.
- R8: With `sqw_sel` = 1 (fast tap, 1024 Hz), `sqw_out` follows bit 1 of the front section's tick count, and a write at address 3 does not shift its phase.
- R9: With `sqw_sel` = 0 (raw tick), `sqw_out` equals `tick_en` of the previous cycle.
- R10: `sqw_out` is low in the cycle after `sqw_en` is low, and it is low whenever `sqw_sel` = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 4096 Hz tick enable, one cycle per tick |
| reg_addr | input | 2 | Register byte address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sqw_en | input | 1 | Square-wave enable |
| sqw_sel | input | 2 | Square-wave source: 0 tick, 1 fast tap, 2 one hertz, 3 off |
| sqw_out | output | 1 | Registered square wave |

## Verification
The count is tested at the tick just before and the tick exactly at a 4096-tick boundary. Together these two checks separate an off-by-one divider from a correct one. The latched copy is read after the live count has carried from 0xFF to 0x100, so a design that reads the live value would return a different byte 1. A load is made while the front section sits at a nonzero phase. The single-tick increment window that follows only matches if the back section alone was cleared. The fast and 1 Hz taps are compared against a tick model across the same load. The raw tick source and the enable are checked with single-tick pulses.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    SQW_TICK   = 2'd0,
    SQW_FAST   = 2'd1,
    SQW_ONE_HZ = 2'd2,
    SQW_OFF    = 2'd3
  } sqw_sel_e;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int FAST_BITS = 2,
  parameter int SLOW_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic restart_slow,
  output logic fast_tap,
  output logic slow_tap,
  output logic sec_carry
);
  localparam logic [FAST_BITS-1:0] FAST_TOP = '1;
  localparam logic [SLOW_BITS-1:0] SLOW_TOP = '1;

  logic [FAST_BITS-1:0] fast_q;
  logic [SLOW_BITS-1:0] slow_q;
  logic                 fast_wrap;

  assign fast_wrap = tick_en && (fast_q == FAST_TOP);
  assign sec_carry = fast_wrap && (slow_q == SLOW_TOP);
  assign fast_tap  = fast_q[FAST_BITS-1];
  assign slow_tap  = slow_q[SLOW_BITS-1];

  // front section: never touched by a load
  always_ff @(posedge clk) begin
    if (rst)
      fast_q <= '0;
    else if (tick_en)
      fast_q <= fast_q + 1'b1;
  end

  // back section: cleared on a count load
  always_ff @(posedge clk) begin
    if (rst)
      slow_q <= '0;
    else if (restart_slow)
      slow_q <= '0;
    else if (fast_wrap)
      slow_q <= slow_q + 1'b1;
  end

  // R6
  slow_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart_slow |=> slow_q == '0);

  // R8
  fast_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_slow && !tick_en) |=> $stable(fast_q));
endmodule

// File: rtl/sec_count_reg.sv
module sec_count_reg #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              load
);
  localparam int NBYTES = CNT_W / DATA_W;
  localparam int STG_W  = CNT_W - DATA_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NBYTES - 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] snap_q;
  logic [STG_W-1:0] stage_q;

  assign load = wr && (addr == TOP_ADDR);

  // staging bytes below the top byte
  for (genvar b = 0; b < NBYTES - 1; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr && addr == ADDR_W'(b))
        stage_q[b*DATA_W +: DATA_W] <= wdata;
    end
  end

  // live count: a load wins over a carry in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (load)
      count_q <= {wdata, stage_q};
    else if (inc)
      count_q <= count_q + 1'b1;
  end

  // holding copy and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      rdata  <= '0;
    end else if (rd) begin
      if (addr == '0) begin
        snap_q <= count_q;
        rdata  <= count_q[DATA_W-1:0];
      end else begin
        rdata  <= snap_q[addr*DATA_W +: DATA_W];
      end
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(count_q));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> count_q == $past(count_q) + 1'b1);

  // R4
  snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd && addr == '0) |=> $stable(snap_q));

  // R5
  stage_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr != TOP_ADDR && !inc) |=> $stable(count_q));
endmodule

// File: rtl/sec_sqw_sel.sv
module sec_sqw_sel
  import sec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       fast_tap,
  input  logic       slow_tap,
  input  logic       en,
  input  sqw_sel_e   sel,
  output logic       sqw_out
);
  logic pick;

  always_comb begin
    unique case (sel)
      SQW_TICK:   pick = tick_en;
      SQW_FAST:   pick = fast_tap;
      SQW_ONE_HZ: pick = slow_tap;
      default:    pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      sqw_out <= 1'b0;
    else
      sqw_out <= en && pick;
  end

  // R10
  sqw_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!en || sel == SQW_OFF) |=> !sqw_out);

  // R9
  sqw_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel == SQW_TICK) |=> sqw_out == $past(tick_en));
endmodule

// File: rtl/sec_counter_top.sv
module sec_counter_top
  import sec_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int FAST_BITS = 2,
  parameter int SLOW_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sqw_en,
  input  logic [1:0]        sqw_sel,
  output logic              sqw_out
);
  logic fast_tap;
  logic slow_tap;
  logic sec_carry;
  logic load;

  sec_prescaler #(
    .FAST_BITS(FAST_BITS),
    .SLOW_BITS(SLOW_BITS)
  ) u_pre (
    .clk(clk),
    .rst(rst),
    .tick_en(tick_en),
    .restart_slow(load),
    .fast_tap(fast_tap),
    .slow_tap(slow_tap),
    .sec_carry(sec_carry)
  );

  sec_count_reg #(
    .CNT_W(CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_cnt (
    .clk(clk),
    .rst(rst),
    .inc(sec_carry),
    .addr(reg_addr),
    .rd(reg_rd),
    .wr(reg_wr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .load(load)
  );

  sec_sqw_sel u_sqw (
    .clk(clk),
    .rst(rst),
    .tick_en(tick_en),
    .fast_tap(fast_tap),
    .slow_tap(slow_tap),
    .en(sqw_en),
    .sel(sqw_sel_e'(sqw_sel)),
    .sqw_out(sqw_out)
  );
endmodule

// File: tb/sec_counter_top_tb.sv
module sec_counter_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sqw_en = 1'b0;
  logic [1:0] sqw_sel = 2'd3;
  logic       sqw_out;

  int checks = 0;
  int fails = 0;
  int m_early = 0;
  int m_late = 0;
  logic [31:0] m_sec = '0;

  always #2 clk = ~clk;

  sec_counter_top u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sqw_en(sqw_en), .sqw_sel(sqw_sel),
    .sqw_out(sqw_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      m_early = (m_early + 1) % 4;
      if (m_early == 0) begin
        m_late = (m_late + 1) % 1024;
        if (m_late == 0) m_sec = m_sec + 1;
      end
    end
    tick_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_count(output logic [31:0] v);
    logic [7:0] b;
    reg_read(2'd0, b); v[7:0] = b;
    reg_read(2'd1, b); v[15:8] = b;
    reg_read(2'd2, b); v[23:16] = b;
    reg_read(2'd3, b); v[31:24] = b;
  endtask

  task automatic load_count(input logic [31:0] v);
    reg_write(2'd0, v[7:0]);
    reg_write(2'd1, v[15:8]);
    reg_write(2'd2, v[23:16]);
    reg_write(2'd3, v[31:24]);
    m_sec = v;
    m_late = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata", {24'd0, reg_rdata}, 32'd0);
    check("R1 sqw", {31'd0, sqw_out}, 32'd0);
    read_count(v);
    check("R1 count", v, 32'd0);
  endtask

  task automatic t_increment();
    logic [31:0] v;
    do_tick(4095);
    read_count(v);
    check("R2 before boundary", v, 32'd0);
    do_tick(1);
    read_count(v);
    check("R2 at boundary", v, 32'd1);
    check("R2 model", v, m_sec);
  endtask

  task automatic t_stage_load();
    logic [31:0] v;
    reg_write(2'd0, 8'h78);
    reg_write(2'd1, 8'h56);
    reg_write(2'd2, 8'h34);
    read_count(v);
    check("R5 staged no effect", v, 32'd1);
    reg_write(2'd3, 8'h12);
    m_sec = 32'h12345678; m_late = 0;
    read_count(v);
    check("R5 load all bytes", v, 32'h12345678);
    check("R3 byte order", v, m_sec);
  endtask

  task automatic t_snapshot();
    logic [7:0] b;
    logic [31:0] v;
    load_count(32'h000000FF);
    reg_read(2'd0, b);
    check("R3 byte0 live", {24'd0, b}, 32'hFF);
    do_tick(4096);
    reg_read(2'd1, b);
    check("R4 frozen byte1", {24'd0, b}, 32'h00);
    read_count(v);
    check("R4 refreshed", v, 32'h100);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    int n;
    do_tick(2);
    load_count(32'hA0000000);
    n = (4 - m_early) + 1023 * 4;
    do_tick(n - 1);
    read_count(v);
    check("R6 one tick early", v, 32'hA0000000);
    do_tick(1);
    read_count(v);
    check("R6 increment after restart", v, 32'hA0000001);
  endtask

  task automatic t_sqw_slow();
    sqw_en = 1'b1; sqw_sel = 2'd2;
    while (m_late < 512) do_tick(4);
    check("R7 high half", {31'd0, sqw_out}, 32'd1);
    load_count(32'd5);
    check("R7 realigned by load", {31'd0, sqw_out}, 32'd0);
    do_tick(512 * 4);
    check("R7 high after half period", {31'd0, sqw_out}, 32'd1);
  endtask

  task automatic t_sqw_fast();
    sqw_sel = 2'd1;
    for (int k = 0; k < 4; k++) begin
      do_tick(1);
      check("R8 fast tap", {31'd0, sqw_out}, 32'((m_early >> 1) & 1));
    end
    while (m_early != 2) do_tick(1);
    load_count(32'd9);
    check("R8 phase kept over load", {31'd0, sqw_out}, 32'd1);
    do_tick(2);
    check("R8 after load", {31'd0, sqw_out}, 32'((m_early >> 1) & 1));
  endtask

  task automatic t_sqw_tick();
    sqw_sel = 2'd0;
    @(negedge clk);
    check("R9 idle", {31'd0, sqw_out}, 32'd0);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    m_early = (m_early + 1) % 4;
    if (m_early == 0) m_late = (m_late + 1) % 1024;
    check("R9 follows tick", {31'd0, sqw_out}, 32'd1);
    @(negedge clk);
    check("R9 drops", {31'd0, sqw_out}, 32'd0);
  endtask

  task automatic t_sqw_off();
    sqw_sel = 2'd1;
    while (m_early < 2) do_tick(1);
    check("R10 tap high enabled", {31'd0, sqw_out}, 32'd1);
    sqw_en = 1'b0;
    @(negedge clk);
    check("R10 disabled", {31'd0, sqw_out}, 32'd0);
    sqw_en = 1'b1; sqw_sel = 2'd3;
    @(negedge clk);
    check("R10 select off", {31'd0, sqw_out}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_increment();
    t_stage_load();
    t_snapshot();
    t_restart();
    t_sqw_slow();
    t_sqw_fast();
    t_sqw_tick();
    t_sqw_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule